// File: doc/BRIEF.md
# Sequenced ADC Conversion Controller

This controller lets a host drive a successive-approximation converter through a small word-addressed register bus. The host fills a table of channel entries and then writes one packed command word. That word selects the operation and carries the sampling window, the resolution and an interrupt-enable bit. The controller then walks the table from entry 0. For each valid entry it sends a start pulse, the channel number, the window and the resolution to the converter. Each returned result is masked to the chosen resolution and pushed into a 32-entry sample FIFO.

A single run stops at the last entry. A continuous run restarts the table after each pass until the host asks it to stop. Calibration commands keep no state of their own: each one completes after a fixed number of cycles. Three sticky status bits (run complete, FIFO overflow and pass complete) are cleared by writing 1 to them. An enable mask gates them onto one interrupt line.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the FIFO count reads 0, the status register (word 1) reads 0, `irq_o` is low, and the enable register (word 2) is 0.
- R2: The command word (word 0) is laid out as follows: window in bits 31:24, resolution code in bits 15:14, entry limit NS in bits 8:4, interrupt-enable IE in bit 3, and operation in bits 2:0. The operation codes are 0 single, 1 continuous, 2/3/4 calibration and 5 stop. Table word 8+w holds entries 4w..4w+3, with entry 4w+k in bits 8k+7:8k. A run converts entries in index order from 0. It ends after the first entry whose bit 7 is set, or after entry NS, whichever comes first.
- R3: An entry's channel is its bits 4:0. An entry whose channel is above 18 is skipped: no conversion starts and no sample is pushed.
- R4: A read of the sample register (word 3) pops the oldest sample into bits 11:0. The sample is the converter's 12-bit result with the low 2×(3−code) bits cleared, where codes 0..3 mean 6, 8, 10 and 12 bits.
- R5: The count register (word 4) reports the FIFO occupancy. A sample read while the FIFO is empty returns 0 and leaves the count unchanged.
- R6: Writing 0xFFFFFFFF to the sample register empties the FIFO, and the count reads 0 from the next cycle.
- R7: The FIFO holds 32 samples. A result that arrives while the FIFO is full is dropped and sets status bit 1.
- R8: Status bit 0 sets when a run ends, after its last sample has been pushed. Writing 1 to a status bit clears it.
- R9: A continuous run restarts from entry 0 after each pass and sets status bit 2 once per pass. A stop command ends the run at the end of the current pass and sets bit 0. After that, no further conversions take place.
- R10: A start command whose window is below 8+2×code (resolution bits + 2) is ignored.
- R11: A calibration command sets status bit 0 exactly CAL_CYCLES cycles after the cycle in which it was written.
- R12: `irq_o` is (bit0 & en0 & IE of the last accepted command) | (bit1 & en1) | (bit2 & en2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW (4) | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_chan_o | output | 5 | Channel for the conversion |
| conv_window_o | output | 8 | Sampling window in converter cycles |
| conv_res_o | output | 2 | Resolution code |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker runs on every cycle. It checks that a start pulse never names a channel above 18 and lasts a single cycle. It checks that the count never exceeds the depth, that a flush empties the FIFO on the next cycle, and that an empty read leaves the count alone. It also checks that a result dropped on a full FIFO raises the overflow bit, and that the interrupt never asserts without an enabled status bit. Only the bench scenarios can show the rest: the order of conversions and where a run ends, the resolution masking of the sample values, how continuous passes and stop behave, rejection of a short window, the exact calibration delay, and gating by the command's interrupt-enable bit.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    OP_SINGLE   = 3'd0,
    OP_CONT     = 3'd1,
    OP_CAL_RST  = 3'd2,
    OP_CAL_RUN  = 3'd3,
    OP_CAL_LOAD = 3'd4,
    OP_STOP     = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_CAL
  } eng_st_e;

  localparam int ADDR_CMD    = 0;
  localparam int ADDR_STAT   = 1;
  localparam int ADDR_IEN    = 2;
  localparam int ADDR_SAMPLE = 3;
  localparam int ADDR_COUNT  = 4;

  localparam int STAT_DONE = 0;
  localparam int STAT_OVF  = 1;
  localparam int STAT_PASS = 2;
  localparam int STAT_W    = 3;

  localparam int SAMPLE_W = 12;
  localparam int CHAN_W   = 5;
  localparam int WIN_W    = 8;

  typedef struct packed {
    logic [WIN_W-1:0] win;
    logic [1:0]       res;
    logic [4:0]       ns;
    logic             ie;
    op_e              op;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.win = w[31:24];
    c.res = w[15:14];
    c.ns  = w[8:4];
    c.ie  = w[3];
    c.op  = op_e'(w[2:0]);
    return c;
  endfunction

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 12,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          drop_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  // a pop in the same cycle frees a slot for the push
  assign do_push = push_i & ~flush_i & (~full_o | do_pop);
  assign drop_o  = push_i & ~flush_i & full_o & ~do_pop;
  assign dout_o  = mem[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_table.sv
module adc_seq_table #(
  parameter int WORDS = 8,
  localparam int WA   = $clog2(WORDS),
  localparam int IW   = WA + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [WA-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    entry_o
);

  logic [31:0] words_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             words_q[g] <= '0;
      else if (we_i && addr_i == WA'(g))       words_q[g] <= wdata_i;
    end
  end

  assign rdata_o = words_q[addr_i];
  assign entry_o = words_q[idx_i[IW-1:2]][idx_i[1:0]*8 +: 8];

endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int IW         = 5,
  parameter int MAX_CHAN   = 18,
  parameter int CAL_CYCLES = 64,
  localparam int CAL_W     = $clog2(CAL_CYCLES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  cmd_t                cmd_i,
  input  logic [7:0]          entry_i,
  output logic [IW-1:0]       idx_o,
  output logic                conv_start_o,
  output logic [CHAN_W-1:0]   conv_chan_o,
  output logic [WIN_W-1:0]    conv_window_o,
  output logic [1:0]          conv_res_o,
  input  logic                conv_done_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                push_o,
  output logic [SAMPLE_W-1:0] push_data_o,
  output logic                cmd_done_o,
  output logic                pass_done_o,
  output logic                ie_o
);

  eng_st_e          st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [1:0]       res_q, res_d;
  logic [4:0]       ns_q, ns_d;
  logic             ie_q, ie_d, cont_q, cont_d, stop_q, stop_d;
  logic [CAL_W-1:0] cal_q, cal_d;

  logic win_ok, is_start, is_cal, chan_ok, last, adv, stop_now;
  logic [3:0]          shamt;
  logic [SAMPLE_W-1:0] mask;

  assign win_ok   = cmd_i.win >= ({5'd0, cmd_i.res, 1'b0} + 8'd8);
  assign is_start = (cmd_i.op == OP_SINGLE) || (cmd_i.op == OP_CONT);
  assign is_cal   = (cmd_i.op == OP_CAL_RST) || (cmd_i.op == OP_CAL_RUN) ||
                    (cmd_i.op == OP_CAL_LOAD);
  assign chan_ok  = entry_i[CHAN_W-1:0] <= CHAN_W'(MAX_CHAN);
  assign last     = entry_i[7] || (32'(idx_q) == 32'(ns_q)) || (&idx_q);
  assign stop_now = cmd_valid_i && (cmd_i.op == OP_STOP) && cont_q &&
                    ((st_q == ST_ISSUE) || (st_q == ST_WAIT));

  assign shamt       = {1'b0, 2'd3 - res_q, 1'b0};
  assign mask        = {SAMPLE_W{1'b1}} << shamt;
  assign push_data_o = conv_data_i & mask;

  assign idx_o         = idx_q;
  assign conv_chan_o   = entry_i[CHAN_W-1:0];
  assign conv_window_o = win_q;
  assign conv_res_o    = res_q;
  assign ie_o          = ie_q;

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  win_d = win_q;  res_d = res_q;
    ns_d = ns_q;  ie_d = ie_q;    cont_d = cont_q; stop_d = stop_q;
    cal_d = cal_q;
    conv_start_o = 1'b0;
    push_o       = 1'b0;
    cmd_done_o   = 1'b0;
    pass_done_o  = 1'b0;
    adv          = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid_i && is_start && win_ok) begin
          win_d  = cmd_i.win;
          res_d  = cmd_i.res;
          ns_d   = cmd_i.ns;
          ie_d   = cmd_i.ie;
          cont_d = (cmd_i.op == OP_CONT);
          stop_d = 1'b0;
          idx_d  = '0;
          st_d   = ST_ISSUE;
        end else if (cmd_valid_i && is_cal) begin
          ie_d  = cmd_i.ie;
          cal_d = '0;
          st_d  = ST_CAL;
        end
      end
      ST_ISSUE: begin
        if (chan_ok) begin
          conv_start_o = 1'b1;
          st_d         = ST_WAIT;
        end else begin
          adv = 1'b1;
        end
      end
      ST_WAIT: begin
        if (conv_done_i) begin
          push_o = 1'b1;
          adv    = 1'b1;
        end
      end
      ST_CAL: begin
        if (cal_q == CAL_W'(CAL_CYCLES - 1)) begin
          cmd_done_o = 1'b1;
          st_d       = ST_IDLE;
        end else begin
          cal_d = cal_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (stop_now) stop_d = 1'b1;

    if (adv) begin
      if (!last) begin
        idx_d = idx_q + 1'b1;
        st_d  = ST_ISSUE;
      end else if (cont_q) begin
        pass_done_o = 1'b1;
        if (stop_q || stop_now) begin
          cmd_done_o = 1'b1;
          cont_d     = 1'b0;
          stop_d     = 1'b0;
          st_d       = ST_IDLE;
        end else begin
          idx_d = '0;
          st_d  = ST_ISSUE;
        end
      end else begin
        cmd_done_o = 1'b1;
        st_d       = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      win_q  <= '0;
      res_q  <= '0;
      ns_q   <= '0;
      ie_q   <= 1'b0;
      cont_q <= 1'b0;
      stop_q <= 1'b0;
      cal_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      win_q  <= win_d;
      res_q  <= res_d;
      ns_q   <= ns_d;
      ie_q   <= ie_d;
      cont_q <= cont_d;
      stop_q <= stop_d;
      cal_q  <= cal_d;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int SEQ_WORDS  = 8,
  parameter int MAX_CHAN   = 18,
  parameter int CAL_CYCLES = 64,
  localparam int WA        = $clog2(SEQ_WORDS),
  localparam int AW        = WA + 1,
  localparam int IW        = WA + 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [AW-1:0]       bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                conv_start_o,
  output logic [CHAN_W-1:0]   conv_chan_o,
  output logic [WIN_W-1:0]    conv_window_o,
  output logic [1:0]          conv_res_o,
  input  logic                conv_done_i,
  input  logic [SAMPLE_W-1:0] conv_data_i,
  output logic                irq_o
);

  logic wr, rd, seq_sel, cmd_wr, samp_rd, flush_wr;
  logic [STAT_W-1:0] status_q, en_q, stat_set;

  logic [IW-1:0]       eng_idx;
  logic [7:0]          entry;
  logic [31:0]         tbl_rdata;
  logic                eng_push, eng_done, eng_pass, eng_ie;
  logic [SAMPLE_W-1:0] eng_data, fifo_dout;
  logic [CNT_W-1:0]    fifo_cnt;
  logic                fifo_full, fifo_empty, fifo_drop;

  assign wr       = bus_req_i & bus_we_i;
  assign rd       = bus_req_i & ~bus_we_i;
  assign seq_sel  = bus_addr_i[AW-1];
  assign cmd_wr   = wr & (bus_addr_i == AW'(ADDR_CMD));
  assign samp_rd  = rd & (bus_addr_i == AW'(ADDR_SAMPLE));
  assign flush_wr = wr & (bus_addr_i == AW'(ADDR_SAMPLE)) & (&bus_wdata_i);

  adc_seq_table #(.WORDS(SEQ_WORDS)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr & seq_sel),
    .addr_i  (bus_addr_i[WA-1:0]),
    .wdata_i (bus_wdata_i),
    .rdata_o (tbl_rdata),
    .idx_i   (eng_idx),
    .entry_o (entry)
  );

  adc_seq_engine #(
    .IW(IW), .MAX_CHAN(MAX_CHAN), .CAL_CYCLES(CAL_CYCLES)
  ) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_wr),
    .cmd_i         (unpack_cmd(bus_wdata_i)),
    .entry_i       (entry),
    .idx_o         (eng_idx),
    .conv_start_o  (conv_start_o),
    .conv_chan_o   (conv_chan_o),
    .conv_window_o (conv_window_o),
    .conv_res_o    (conv_res_o),
    .conv_done_i   (conv_done_i),
    .conv_data_i   (conv_data_i),
    .push_o        (eng_push),
    .push_data_o   (eng_data),
    .cmd_done_o    (eng_done),
    .pass_done_o   (eng_pass),
    .ie_o          (eng_ie)
  );

  adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .DW(SAMPLE_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (eng_push),
    .din_i   (eng_data),
    .pop_i   (samp_rd),
    .flush_i (flush_wr),
    .dout_o  (fifo_dout),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  always_comb begin
    stat_set            = '0;
    stat_set[STAT_DONE] = eng_done;
    stat_set[STAT_OVF]  = fifo_drop;
    stat_set[STAT_PASS] = eng_pass;
  end

  // set wins over a same-cycle write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      if (wr && bus_addr_i == AW'(ADDR_STAT))
        status_q <= (status_q & ~bus_wdata_i[STAT_W-1:0]) | stat_set;
      else
        status_q <= status_q | stat_set;
      if (wr && bus_addr_i == AW'(ADDR_IEN))
        en_q <= bus_wdata_i[STAT_W-1:0];
    end
  end

  assign irq_o = (status_q[STAT_DONE] & en_q[STAT_DONE] & eng_ie) |
                 (status_q[STAT_OVF]  & en_q[STAT_OVF]) |
                 (status_q[STAT_PASS] & en_q[STAT_PASS]);

  always_comb begin
    bus_rdata_o = '0;
    if (seq_sel) begin
      bus_rdata_o = tbl_rdata;
    end else begin
      case (32'(bus_addr_i))
        ADDR_STAT:   bus_rdata_o = 32'(status_q);
        ADDR_IEN:    bus_rdata_o = 32'(en_q);
        ADDR_SAMPLE: bus_rdata_o = fifo_empty ? '0 : 32'(fifo_dout);
        ADDR_COUNT:  bus_rdata_o = 32'(fifo_cnt);
        default:     bus_rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int MAX_CHAN   = 18,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_start_o,
  input logic [CHAN_W-1:0] conv_chan_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] en_q,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              fifo_full,
  input logic              eng_push,
  input logic              samp_rd,
  input logic              flush_wr
);

  assert_valid_chan_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> conv_chan_o <= CHAN_W'(MAX_CHAN));

  assert_start_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  assert_drop_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_push && fifo_full && !samp_rd && !flush_wr) |=> status_q[STAT_OVF]);

  assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_wr |=> fifo_cnt == '0);

  assert_empty_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_rd && fifo_cnt == '0 && !eng_push) |=> fifo_cnt == '0);

  assert_irq_source_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q & en_q) != '0);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .FIFO_DEPTH(FIFO_DEPTH), .MAX_CHAN(MAX_CHAN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .irq_o        (irq_o),
  .status_q     (status_q),
  .en_q         (en_q),
  .fifo_cnt     (fifo_cnt),
  .fifo_full    (fifo_full),
  .eng_push     (eng_push),
  .samp_rd      (samp_rd),
  .flush_wr     (flush_wr)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  import adc_seq_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req, we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        conv_start, conv_done, irq;
  logic [4:0]  conv_chan;
  logic [7:0]  conv_window;
  logic [1:0]  conv_res;
  logic [11:0] conv_data;

  int checks = 0;
  int fails  = 0;

  adc_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_window_o(conv_window), .conv_res_o(conv_res),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .irq_o(irq)
  );

  function automatic logic [11:0] md(input logic [4:0] ch);
    return 12'hFFF - 12'(ch) * 12'd73;
  endfunction

  // behavioural converter: result valid window cycles after start
  logic [7:0] m_cnt;
  logic [4:0] m_ch;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0;
      m_ch  <= '0;
    end else if (conv_start) begin
      m_cnt <= conv_window;
      m_ch  <= conv_chan;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1'b1;
    end
  end
  assign conv_done = (m_cnt == 8'd1);
  assign conv_data = md(m_ch);

  function automatic logic [31:0] mk(input logic [7:0] win, input logic [1:0] res,
                                     input logic [4:0] ns, input logic ie, input op_e op);
    return {win, 8'h00, res, 5'h00, ns, ie, op};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic wait_bit(input int b, input string tag);
    logic [31:0] s;
    bit seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      br(4'd1, s);
      seen = s[b];
    end
    chk(seen, tag, 32'(seen), 32'd1);
  endtask

  // {word0, word1, res, ns, win}
  localparam logic [78:0] VEC [4] = '{
    {32'h00800703, 32'h00000000, 2'd3, 5'd31, 8'd14},
    {32'h00921301, 32'h00000000, 2'd0, 5'd31, 8'd8},
    {32'h05040302, 32'h00000000, 2'd1, 5'd2,  8'd10},
    {32'h0C0B0A09, 32'h00008D11, 2'd2, 5'd31, 8'd12}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    req = 0; we = 0; addr = 0; wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    br(4'd4, d); chk(d == 0, "R1 count", d, 0);
    br(4'd1, d); chk(d == 0, "R1 status", d, 0);
    br(4'd2, d); chk(d == 0, "R1 enable", d, 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    // R5 empty read
    br(4'd3, d); chk(d == 0, "R5 empty sample", d, 0);
    br(4'd4, d); chk(d == 0, "R5 count after empty read", d, 0);

    // R2 R3 R4 vector walk
    for (int v = 0; v < 4; v++) begin
      logic [31:0] w0, w1;
      logic [1:0]  res;
      logic [4:0]  ns;
      logic [7:0]  win;
      logic [63:0] ent;
      logic [11:0] mask;
      int          exp_ch [32];
      int          n;
      string       tag;
      {w0, w1, res, ns, win} = VEC[v];
      ent  = {w1, w0};
      mask = 12'hFFF << (2 * (3 - res));
      tag  = (v == 1) ? "R3" : "R2";
      n = 0;
      for (int i = 0; i < 8; i++) begin
        logic [7:0] e;
        e = ent[8*i +: 8];
        if (e[4:0] <= 5'd18) begin
          exp_ch[n] = int'(e[4:0]);
          n++;
        end
        if (e[7] || i == int'(ns)) break;
      end
      bw(4'd8, w0);
      bw(4'd9, w1);
      bw(4'd3, 32'hFFFF_FFFF);
      bw(4'd1, 32'h7);
      bw(4'd0, mk(win, res, ns, 1'b0, OP_SINGLE));
      wait_bit(0, "R8 done");
      br(4'd4, d); chk(d == 32'(n), tag, d, 32'(n));
      for (int k = 0; k < n; k++) begin
        logic [11:0] ex;
        ex = md(5'(exp_ch[k])) & mask;
        br(4'd3, d); chk(d == 32'(ex), "R4 sample", d, 32'(ex));
      end
      br(4'd4, d); chk(d == 0, "R4 popped all", d, 0);
    end

    // R10 window too short for 12 bits
    bw(4'd1, 32'h7);
    bw(4'd0, mk(8'd13, 2'd3, 5'd31, 1'b0, OP_SINGLE));
    repeat (100) @(posedge clk);
    br(4'd1, d); chk(d == 0, "R10 status", d, 0);
    br(4'd4, d); chk(d == 0, "R10 count", d, 0);

    // R7 R9 continuous until overflow, then stop
    bw(4'd8, 32'h00000085);
    bw(4'd0, mk(8'd8, 2'd0, 5'd0, 1'b0, OP_CONT));
    wait_bit(1, "R7 overflow");
    br(4'd4, d); chk(d == 32, "R7 count full", d, 32);
    br(4'd1, d); chk(d[2] == 1'b1, "R9 pass bit", 32'(d[2]), 1);
    bw(4'd0, mk(8'd0, 2'd0, 5'd0, 1'b0, OP_STOP));
    wait_bit(0, "R9 stop done");
    bw(4'd1, 32'h7);
    repeat (60) @(posedge clk);
    br(4'd1, d); chk(d == 0, "R9 idle after stop", d, 0);
    br(4'd4, d); chk(d == 32, "R7 count kept", d, 32);
    // R6 flush
    bw(4'd3, 32'hFFFF_FFFF);
    br(4'd4, d); chk(d == 0, "R6 flush", d, 0);

    // R12 irq gating, R8 write-1-clear
    bw(4'd2, 32'h1);
    bw(4'd8, 32'h00000081);
    bw(4'd0, mk(8'd8, 2'd0, 5'd0, 1'b0, OP_SINGLE));
    wait_bit(0, "R8 done ie0");
    chk(irq == 1'b0, "R12 irq ie0", 32'(irq), 0);
    bw(4'd1, 32'h1);
    br(4'd1, d); chk(d == 0, "R8 w1c", d, 0);
    bw(4'd0, mk(8'd8, 2'd0, 5'd0, 1'b1, OP_SINGLE));
    wait_bit(0, "R8 done ie1");
    #1 chk(irq == 1'b1, "R12 irq ie1", 32'(irq), 1);
    bw(4'd1, 32'h1);
    #1 chk(irq == 1'b0, "R12 irq cleared", 32'(irq), 0);
    bw(4'd2, 32'h0);
    bw(4'd3, 32'hFFFF_FFFF);

    // R11 calibration delay
    bw(4'd1, 32'h7);
    bw(4'd0, mk(8'd0, 2'd0, 5'd0, 1'b0, OP_CAL_RUN));
    repeat (63) @(posedge clk);
    br(4'd1, d); chk(d[0] == 1'b0, "R11 not yet", 32'(d[0]), 0);
    br(4'd1, d); chk(d[0] == 1'b1, "R11 done", 32'(d[0]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule